// File: doc/BRIEF.md
# Power-Managed Serial ADC Read Controller

This block is the host-side master for a three-wire serial converter link: an active-low chip-select, a serial clock and one serial data line coming back from the converter. From the system clock it makes the serial clock with a programmable divider. It shifts the returned bits into a register and presents the 10-bit conversion result as a parallel word. A caller starts a job with a one-cycle `start` strobe and a mode bit. The block raises `busy` while the job runs and pulses `done` for one system clock when the job is over.

A read job keeps chip-select low for a whole 16-clock frame and returns the sample. A power-down job deliberately cuts the frame short. Chip-select is released after a small, parameter-chosen number of falling serial-clock edges, always at least two and at most nine, so the converter drops into shutdown. The controller keeps its own record of whether the converter is asleep. It assumes the converter is asleep after reset. A read issued while the converter sleeps first runs a full wake frame and throws its data away. It then holds chip-select high for a programmable power-up wait before the real read frame. When the duty-cycle input is set along with a read, the block appends a power-down frame after the read, so the converter spends the idle time between samples in shutdown. This trades throughput for power.

Top module: `adc_pm_reader`

## Requirements
- R1: After reset `cs_n` and `sclk` are high, `busy`, `done` and `data_valid` are low, and `sclk` is high in every cycle in which `cs_n` is high.
- R2: A read frame holds `cs_n` low across exactly 16 falling edges of `sclk`.
- R3: `sdata` is sampled on each rising edge of `sclk`, first bit first, so the first bit sampled is frame bit 15. `data` equals frame bits 12 down to 3, with frame bit 12 on `data[9]`.
- R4: A power-down frame releases `cs_n` after exactly PD_EDGES falling edges (default 4, legal range 2 to 9), before the next falling edge. The converter is then taken as asleep.
- R5: A read requested while the converter is asleep first runs a 16-edge wake frame whose data is discarded. It then keeps `cs_n` high for at least WAKE_CYC system clocks before the read frame.
- R6: A read with `duty_en` high is followed, within the same job, by a power-down frame. The next read therefore wakes the converter first.
- R7: `cs_n` stays low for at least DIV system clocks (one half serial period) before the first falling edge of `sclk`. It stays low for at least DIV clocks after the last rising edge. It stays high for at least DIV clocks between frames.
- R8: `done` is high for exactly one system clock at the end of each job, in the cycle in which `busy` is already low. After a read job `data_valid` is 1 and `data` holds the new result. After a power-down job `data_valid` is 0 and `data` keeps its previous value.
- R9: A `start` that arrives while `busy` is high is ignored and produces no frame.
- R10: `busy` is high in the cycle after an accepted `start`. After reset the first read begins with a wake frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle job request, taken only while idle |
| mode | input | 1 | Job type: 0 read, 1 power-down |
| duty_en | input | 1 | With a read, append a power-down frame |
| busy | output | 1 | High while a job is in progress |
| done | output | 1 | One-cycle pulse when a job ends |
| data | output | DATA_BITS | Last conversion result |
| data_valid | output | 1 | 1 after a read job, 0 after a power-down job |
| cs_n | output | 1 | Converter chip-select, active low |
| sclk | output | 1 | Serial clock, idles high |
| sdata | input | 1 | Serial data from the converter |

## Verification
A wrong sleep flag shows at the first `cs_n` fall of the next read job, as a wake frame that is missing or one too many. A serial model that also tracks sleep would return the wrong word at that job's `done`. A bad edge counter shows at the very next rising edge of `cs_n`, as a frame of the wrong length. A misaligned capture shows at the next read's `done` as a shifted result. Timing faults on the serial pins show within one frame, as a setup, hold or gap shorter than half a serial period, or shorter than the power-up wait after a wake frame.

// File: rtl/adc_pm_pkg.sv
// Shared types for the power-managed serial ADC read controller.
// Assumes: a single clock domain; all users compile this package first.
package adc_pm_pkg;

    // Sequencer states: idle, chip-select setup, serial clock low/high
    // halves, inter-frame gap, and power-up wait after a wake frame.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LOW,
        ST_HIGH,
        ST_GAP,
        ST_WAIT
    } seq_state_t;

    // Kind of frame being run inside a job.
    typedef enum logic [1:0] {
        FR_WAKE,
        FR_READ,
        FR_SLEEP
    } frame_kind_t;

    localparam logic MODE_READ  = 1'b0;
    localparam logic MODE_SLEEP = 1'b1;

endpackage

// File: rtl/adc_pm_tick.sv
// Half-period timebase: pulses tick on the last of every DIV system clocks.
// Assumes: DIV >= 2; clr restarts the count so the next state lasts DIV clocks.
module adc_pm_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = $clog2(DIV + 1);

    logic [CW-1:0] cnt;

    // Count system clocks within one half serial period.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (cnt == CW'(DIV - 1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = (cnt == CW'(DIV - 1));

endmodule

// File: rtl/adc_pm_capture.sv
// Serial-to-parallel capture: shifts sdata in on each shift_en strobe,
// first bit first. Only the low DATA_LSB+DATA_BITS bits are stored; after a
// full frame they hold frame bits down to 0, so the field is taken directly.
// Assumes: shift_en coincides with the rising edge of the serial clock.
module adc_pm_capture #(
    parameter int DATA_BITS = 10,
    parameter int DATA_LSB  = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift_en,
    input  logic                 sdata,
    output logic [DATA_BITS-1:0] field
);
    localparam int SW = DATA_LSB + DATA_BITS;

    logic [SW-1:0] shreg;

    // Shift the sampled serial bit in at the low end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (shift_en) begin
            shreg <= {shreg[SW-2:0], sdata};
        end
    end

    assign field = shreg[SW-1 -: DATA_BITS];

endmodule

// File: rtl/adc_pm_seq.sv
// Job sequencer: builds wake, read and power-down frames, drives the
// registered chip-select and serial clock, tracks converter sleep state and
// reports done/valid.
// Assumes: the converter is asleep after reset; tick marks the end of each
// half serial period; 2 <= PD_EDGES <= 9; WAKE_CYC >= 1.
module adc_pm_seq
    import adc_pm_pkg::*;
#(
    parameter int FRAME_BITS = 16,
    parameter int PD_EDGES   = 4,
    parameter int WAKE_CYC   = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic mode,
    input  logic duty_en,
    input  logic tick,
    output logic tick_clr,
    output logic shift_en,
    output logic latch,
    output logic busy,
    output logic done,
    output logic data_valid,
    output logic cs_n,
    output logic sclk
);
    localparam int CW = $clog2(FRAME_BITS + 1);
    localparam int WW = $clog2(WAKE_CYC + 1);

    seq_state_t  state, state_nx;
    frame_kind_t kind, kind_nx;
    logic [CW-1:0] edges;
    logic [WW-1:0] wcnt;
    logic asleep, job_duty, job_sleep, finish;
    logic done_q, valid_q, cs_q, sclk_q;

    // Number of serial clock cycles in a frame of the given kind.
    function automatic logic [CW-1:0] frame_len(input frame_kind_t k);
        return (k == FR_SLEEP) ? CW'(PD_EDGES) : CW'(FRAME_BITS);
    endfunction

    // Next-state, frame selection and end-of-job decisions.
    always_comb begin
        state_nx = state;
        kind_nx  = kind;
        finish   = 1'b0;
        latch    = 1'b0;
        case (state)
            ST_IDLE: if (start) begin
                state_nx = ST_SETUP;
                kind_nx  = (mode == MODE_SLEEP) ? FR_SLEEP :
                           (asleep ? FR_WAKE : FR_READ);
            end
            ST_SETUP: if (tick) state_nx = ST_LOW;
            ST_LOW:   if (tick) state_nx = ST_HIGH;
            ST_HIGH:  if (tick) state_nx = (edges == frame_len(kind)) ? ST_GAP : ST_LOW;
            ST_GAP: if (tick) begin
                case (kind)
                    FR_WAKE: state_nx = ST_WAIT;
                    FR_READ: begin
                        latch = 1'b1;
                        if (job_duty) begin
                            kind_nx  = FR_SLEEP;
                            state_nx = ST_SETUP;
                        end else begin
                            finish   = 1'b1;
                            state_nx = ST_IDLE;
                        end
                    end
                    default: begin
                        finish   = 1'b1;
                        state_nx = ST_IDLE;
                    end
                endcase
            end
            ST_WAIT: if (wcnt == WW'(WAKE_CYC - 1)) begin
                kind_nx  = FR_READ;
                state_nx = ST_SETUP;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State, counters, sleep tracking and registered pin outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            kind      <= FR_READ;
            edges     <= '0;
            wcnt      <= '0;
            asleep    <= 1'b1;
            job_duty  <= 1'b0;
            job_sleep <= 1'b0;
            done_q    <= 1'b0;
            valid_q   <= 1'b0;
            cs_q      <= 1'b1;
            sclk_q    <= 1'b1;
        end else begin
            state  <= state_nx;
            kind   <= kind_nx;
            done_q <= finish;
            if (state == ST_IDLE && start) begin
                job_duty  <= duty_en && (mode == MODE_READ);
                job_sleep <= (mode == MODE_SLEEP);
            end
            if (state_nx == ST_SETUP) begin
                edges <= '0;
            end else if (state == ST_LOW && tick) begin
                edges <= edges + 1'b1;
            end
            wcnt <= (state == ST_WAIT) ? wcnt + 1'b1 : '0;
            if (state == ST_GAP && tick) begin
                asleep <= (kind == FR_SLEEP);
            end
            if (finish) begin
                valid_q <= !job_sleep;
            end
            cs_q   <= !(state_nx inside {ST_SETUP, ST_LOW, ST_HIGH});
            sclk_q <= (state_nx != ST_LOW);
        end
    end

    assign tick_clr   = (state == ST_IDLE) || (state == ST_WAIT);
    assign shift_en   = (state == ST_LOW) && tick;
    assign busy       = (state != ST_IDLE);
    assign done       = done_q;
    assign data_valid = valid_q;
    assign cs_n       = cs_q;
    assign sclk       = sclk_q;

endmodule

// File: rtl/adc_pm_reader.sv
// Top of the power-managed serial ADC read controller: timebase, sequencer,
// serial capture and the parallel result register.
// Assumes: sdata changes on the falling serial clock edge and is stable at
// the following rising edge; DIV >= 2.
module adc_pm_reader #(
    parameter int DIV        = 4,
    parameter int FRAME_BITS = 16,
    parameter int DATA_BITS  = 10,
    parameter int DATA_LSB   = 3,
    parameter int PD_EDGES   = 4,
    parameter int WAKE_CYC   = 50
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 mode,
    input  logic                 duty_en,
    output logic                 busy,
    output logic                 done,
    output logic [DATA_BITS-1:0] data,
    output logic                 data_valid,
    output logic                 cs_n,
    output logic                 sclk,
    input  logic                 sdata
);
    logic tick, tick_clr, shift_en, latch;
    logic [DATA_BITS-1:0] field;
    logic [DATA_BITS-1:0] data_q;

    adc_pm_tick #(.DIV(DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tick_clr),
        .tick  (tick)
    );

    adc_pm_seq #(
        .FRAME_BITS (FRAME_BITS),
        .PD_EDGES   (PD_EDGES),
        .WAKE_CYC   (WAKE_CYC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .mode       (mode),
        .duty_en    (duty_en),
        .tick       (tick),
        .tick_clr   (tick_clr),
        .shift_en   (shift_en),
        .latch      (latch),
        .busy       (busy),
        .done       (done),
        .data_valid (data_valid),
        .cs_n       (cs_n),
        .sclk       (sclk)
    );

    adc_pm_capture #(
        .DATA_BITS (DATA_BITS),
        .DATA_LSB  (DATA_LSB)
    ) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .sdata    (sdata),
        .field    (field)
    );

    // Hold the result of the last completed read frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (latch) begin
            data_q <= field;
        end
    end

    assign data = data_q;

endmodule

// File: rtl/adc_pm_chk.sv
// Protocol checker for adc_pm_reader, attached by bind. Watches only the
// serial pins and the job handshake.
// Assumes: synchronous active-low reset shared with the design.
module adc_pm_chk #(
    parameter int DIV        = 4,
    parameter int FRAME_BITS = 16,
    parameter int PD_EDGES   = 4
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sclk,
    input logic busy,
    input logic done
);
    localparam int HW      = $clog2(DIV + 2);
    localparam int FW      = $clog2(FRAME_BITS + 2);
    localparam int MIN_SLP = 2;
    localparam int MAX_SLP = 10;

    logic          cs_d, sclk_d;
    logic [HW-1:0] hi_cnt, cs_hi_cnt;
    logic [FW-1:0] fall_cnt;
    logic [2:0]    job_frames;

    // Track edges, high-phase lengths and frames per job.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_d       <= 1'b1;
            sclk_d     <= 1'b1;
            hi_cnt     <= HW'(DIV);
            cs_hi_cnt  <= HW'(DIV);
            fall_cnt   <= '0;
            job_frames <= '0;
        end else begin
            cs_d   <= cs_n;
            sclk_d <= sclk;
            if (!sclk) hi_cnt <= '0;
            else if (hi_cnt < HW'(DIV)) hi_cnt <= hi_cnt + 1'b1;
            if (!cs_n) cs_hi_cnt <= '0;
            else if (cs_hi_cnt < HW'(DIV)) cs_hi_cnt <= cs_hi_cnt + 1'b1;
            if (cs_d && !cs_n) fall_cnt <= '0;
            else if (sclk_d && !sclk && !cs_n) fall_cnt <= fall_cnt + 1'b1;
            if (!busy) job_frames <= '0;
            else if (cs_d && !cs_n) job_frames <= job_frames + 1'b1;
        end
    end

    // R1
    sclk_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> sclk);

    // R2
    frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && !cs_d) |-> (fall_cnt == FW'(FRAME_BITS) || fall_cnt == FW'(PD_EDGES)));

    // R4
    sleep_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && !cs_d && fall_cnt < FW'(MAX_SLP)) |-> (fall_cnt >= FW'(MIN_SLP)));

    // R7
    cs_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_d && !sclk) |-> (hi_cnt >= HW'(DIV)));

    // R7
    cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && !cs_d) |-> (hi_cnt >= HW'(DIV)));

    // R7
    cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_d && !cs_n) |-> (cs_hi_cnt >= HW'(DIV)));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9
    job_frames_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (job_frames <= 3'd3));

endmodule

bind adc_pm_reader adc_pm_chk #(
    .DIV        (DIV),
    .FRAME_BITS (FRAME_BITS),
    .PD_EDGES   (PD_EDGES)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (cs_n),
    .sclk  (sclk),
    .busy  (busy),
    .done  (done)
);

// File: tb/adc_pm_reader_bench.sv
// Scoreboard bench: a converter model drives sdata and tracks sleep state;
// the driver task queues expected frames and results, monitors compare.
module adc_pm_reader_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 4;
    localparam int PD_EDGES   = 4;
    localparam int WAKE_CYC   = 50;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic mode = 1'b0;
    logic duty_en = 1'b0;
    logic busy, done, data_valid, cs_n, sclk;
    logic sdata = 1'b0;
    logic [9:0] data;

    int tests = 0;
    int fails = 0;

    int    exp_len_q[$];
    int    exp_gap_q[$];
    string exp_tag_q[$];
    logic  exp_valid_q[$];
    logic [9:0] exp_data_q[$];

    bit         exp_asleep = 1'b1;
    logic [9:0] last_data  = '0;
    logic [15:0] cur_word  = '0;

    adc_pm_reader #(
        .DIV      (DIV),
        .PD_EDGES (PD_EDGES),
        .WAKE_CYC (WAKE_CYC)
    ) u_adc_pm_reader (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .mode       (mode),
        .duty_en    (duty_en),
        .busy       (busy),
        .done       (done),
        .data       (data),
        .data_valid (data_valid),
        .cs_n       (cs_n),
        .sclk       (sclk),
        .sdata      (sdata)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // Converter model and pin monitor, sampled on the falling system clock.
    int          cyc = 0;
    logic        prev_cs = 1'b1, prev_sclk = 1'b1;
    bit          slv_asleep = 1'b1;
    int          nfall = 0;
    int          t_cs_rise = -100000, t_cs_fall = 0, t_sclk_rise = 0;
    logic [15:0] shown = '0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (prev_cs && !cs_n) begin
                // frame start: gap check against queued expectation (R5, R7)
                if (exp_gap_q.size() > 0)
                    chk(cyc - t_cs_rise >= exp_gap_q[0], "R7/R5 cs high gap", cyc - t_cs_rise, exp_gap_q[0]);
                else
                    chk(1'b0, "R9 unexpected frame", 1, 0);
                t_cs_fall = cyc;
                nfall = 0;
                shown = slv_asleep ? ~cur_word : cur_word;
            end
            if (!cs_n && prev_sclk && !sclk) begin
                if (nfall == 0) chk(cyc - t_cs_fall >= DIV, "R7 cs setup", cyc - t_cs_fall, DIV);
                if (nfall < 16) sdata = shown[15 - nfall];
                nfall++;
            end
            if (!cs_n && !prev_sclk && sclk) t_sclk_rise = cyc;
            if (!prev_cs && cs_n) begin
                chk(cyc - t_sclk_rise >= DIV, "R7 cs hold", cyc - t_sclk_rise, DIV);
                if (exp_len_q.size() > 0) begin
                    chk(nfall == exp_len_q[0], exp_tag_q[0], nfall, exp_len_q[0]);
                    void'(exp_len_q.pop_front());
                    void'(exp_gap_q.pop_front());
                    void'(exp_tag_q.pop_front());
                end
                if (nfall >= 2 && nfall < 10) slv_asleep = 1'b1;
                else if (nfall >= 10) slv_asleep = 1'b0;
                t_cs_rise = cyc;
            end
            if (done) begin
                if (exp_valid_q.size() > 0) begin
                    chk(data_valid == exp_valid_q[0], "R8 data_valid", int'(data_valid), int'(exp_valid_q[0]));
                    chk(data == exp_data_q[0], "R3 data", int'(data), int'(exp_data_q[0]));
                    chk(!busy, "R8 busy low at done", int'(busy), 0);
                    void'(exp_valid_q.pop_front());
                    void'(exp_data_q.pop_front());
                end else begin
                    chk(1'b0, "R9 unexpected done", 1, 0);
                end
            end
            prev_cs   = cs_n;
            prev_sclk = sclk;
        end
    end

    // Driver: queue expectations, then issue one job and wait for done.
    task automatic run_job(input logic md, input logic duty, input logic [15:0] word);
        cur_word = word;
        if (md) begin
            exp_len_q.push_back(PD_EDGES); exp_gap_q.push_back(DIV); exp_tag_q.push_back("R4 sleep frame");
            exp_asleep = 1'b1;
            exp_valid_q.push_back(1'b0); exp_data_q.push_back(last_data);
        end else begin
            if (exp_asleep) begin
                exp_len_q.push_back(16); exp_gap_q.push_back(DIV); exp_tag_q.push_back("R5 wake frame");
            end
            exp_len_q.push_back(16);
            exp_gap_q.push_back(exp_asleep ? WAKE_CYC : DIV);
            exp_tag_q.push_back("R2 read frame");
            if (duty) begin
                exp_len_q.push_back(PD_EDGES); exp_gap_q.push_back(DIV); exp_tag_q.push_back("R6 duty sleep frame");
            end
            exp_asleep = duty;
            last_data = word[12:3];
            exp_valid_q.push_back(1'b1); exp_data_q.push_back(word[12:3]);
        end
        @(negedge clk);
        start = 1'b1; mode = md; duty_en = duty;
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R10 busy after start", int'(busy), 1);
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cs_n == 1'b1, "R1 cs_n idle", int'(cs_n), 1);
        chk(sclk == 1'b1, "R1 sclk idle", int'(sclk), 1);
        chk(busy == 1'b0, "R1 busy idle", int'(busy), 0);
        chk(done == 1'b0, "R1 done idle", int'(done), 0);
        chk(data_valid == 1'b0, "R1 valid idle", int'(data_valid), 0);

        run_job(1'b0, 1'b0, 16'hA5C3);   // R10: first read wakes
        run_job(1'b0, 1'b0, 16'h3C96);   // awake read
        run_job(1'b0, 1'b1, 16'h5A5A);   // R6 duty read
        run_job(1'b0, 1'b0, 16'hFFFF);   // wake after duty
        run_job(1'b1, 1'b0, 16'h0000);   // R4 power-down job
        run_job(1'b0, 1'b0, 16'h0000);   // wake after power-down
        run_job(1'b0, 1'b0, 16'h1FF8);   // field all ones
        run_job(1'b0, 1'b0, 16'hE007);   // field all zeros, outer bits set

        // R9: a start during a job is ignored
        cur_word = 16'h2AA8;
        exp_len_q.push_back(16); exp_gap_q.push_back(DIV); exp_tag_q.push_back("R2 read frame");
        exp_valid_q.push_back(1'b1); exp_data_q.push_back(10'h155);
        @(negedge clk);
        start = 1'b1; mode = 1'b0; duty_en = 1'b0;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        start = 1'b1; mode = 1'b1;
        @(negedge clk);
        start = 1'b0; mode = 1'b0;
        while (!done) @(negedge clk);
        repeat (200) @(negedge clk);
        chk(busy == 1'b0 && cs_n == 1'b1, "R9 no job after ignored start", int'(busy), 0);
        chk(exp_len_q.size() == 0, "R9 frame queue empty", exp_len_q.size(), 0);
        chk(exp_valid_q.size() == 0, "R8 result queue empty", exp_valid_q.size(), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule